// File: doc/BRIEF.md
# Latency-hiding texture cache with in-order retirement

This block is a read-only cache for texture fetches that keeps the tag lookup apart from the delivery of data. When a request is accepted, the tags are looked up and a line is claimed in the same cycle. A miss also sends a line-sized read towards memory. The access then waits in a fragment queue until its data can be delivered. Because of this, later requests keep flowing while earlier misses are still outstanding. A tag hit is reported as "pending": the data is not ready at once, because the access has to pass through the same queue behind any older misses.

Each miss gets a slot in a reorder buffer. The slot number goes out with the memory request, and memory returns it with the fill. Fills may come back in any order; each one only marks its slot ready. A retire stage takes the oldest fragment. A hit fragment moves on at once. A miss fragment waits until the reorder-buffer head is ready. Retired accesses enter a small result queue that the consumer drains. Accesses therefore leave in exactly the order they were accepted, whatever the fill latency.

Top module: `tex_prefetch_cache`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req_valid` are 0.
- R2: A request is refused when the fragment queue, the request queue or the reorder buffer is full. A refused request has status 2'b00. It produces no response and no memory request.
- R3: An accepted request reports status 2'b01 on a tag hit and 2'b10 on a tag miss, combinationally in the cycle `req_valid` is high. No status means "data ready now".
- R4: A miss marks its tag valid at acceptance. A later access to the same line reports a hit before the fill has returned.
- R5: The set index is the block-address bits just above the byte offset. A miss fills the lowest-numbered invalid way, otherwise the least recently used way. The response gives the line index as set*WAYS+way and returns the request's byte offset within the line.
- R6: Each miss issues exactly one memory request with the line-aligned address. The request stays on `mem_req_valid`/`mem_req_addr`/`mem_req_slot` unchanged while `mem_full` is high. It is consumed in a cycle where `mem_full` is low.
- R7: Reorder-buffer slots are handed out circularly in acceptance order, starting at 0 after reset, and carried on `mem_req_slot`. A fill names its slot on `fill_slot`, and fills may return in any order.
- R8: Responses leave in strict acceptance order. A hit that follows an unfilled miss is not delivered before that miss.
- R9: The head response stays on `rsp_valid`/`rsp_id` until `rsp_pop`. While the result queue is full, retirement stalls and no response is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_id | input | ID_W | Tag carried through to the response |
| req_status | output | 2 | 00 refused, 01 hit pending, 10 miss |
| mem_full | input | 1 | Memory port cannot take a request this cycle |
| mem_req_valid | output | 1 | Line read waiting at the memory port |
| mem_req_addr | output | ADDR_W | Line-aligned read address |
| mem_req_slot | output | SLOT_W | Reorder-buffer slot owned by this read |
| fill_valid | input | 1 | A line has returned from memory |
| fill_slot | input | SLOT_W | Slot the returning line belongs to |
| rsp_pop | input | 1 | Consumer takes the head response |
| rsp_valid | output | 1 | A completed access is available |
| rsp_id | output | ID_W | Tag of the completed access |
| rsp_line | output | LINE_W | Cache line index holding its data |
| rsp_off | output | OFF_W | Byte offset of the access within the line |

## Verification
The bench builds the cache with 2 sets of 2 ways, 32-byte lines, a 6-entry fragment queue, a 2-entry request queue, a 3-entry reorder buffer and a 2-entry result queue. At these sizes, each of the three refusal conditions can be reached on its own with a few accesses. LRU eviction in both sets shows up within four misses, and the slot counter wraps several times. The small result queue lets backpressure stall retirement while a hit is still waiting behind a filled miss. The out-of-order fill cases check that an early fill for a younger miss does not release it ahead of an older one.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Outcome of an access attempt, reported in the cycle of the request.
    typedef enum logic [1:0] {
        ST_REFUSED     = 2'b00,
        ST_HIT_PENDING = 2'b01,
        ST_MISS        = 2'b10
    } acc_status_e;

    // Number of bits needed to hold values 0..n-1 (at least 1).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tpc_fifo.sv
module tpc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = tpc_pkg::idx_bits(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tpc_rob.sv
module tpc_rob #(
    parameter int W      = 8,
    parameter int DEPTH  = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [W-1:0]      din,
    output logic [SLOT_W-1:0] push_slot,
    input  logic              pop,
    output logic [W-1:0]      head,
    output logic              head_ready,
    output logic              full,
    output logic              empty,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]      ent [DEPTH];
    logic [DEPTH-1:0]  rdy_q;
    logic [SLOT_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;

    assign push_slot  = wr_q;
    assign head       = ent[rd_q];
    assign head_ready = rdy_q[rd_q];
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (push) ent[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            rdy_q <= '0;
        end else begin
            if (fill_valid) rdy_q[fill_slot] <= 1'b1;
            if (push) begin
                rdy_q[wr_q] <= 1'b0;
                wr_q <= (wr_q == SLOT_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) rd_q <= (rd_q == SLOT_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tpc_tags.sv
module tpc_tags #(
    parameter int BLK_W  = 27,
    parameter int NSETS  = 8,
    parameter int WAYS   = 20,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_en,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              hit,
    output logic [LINE_W-1:0] line
);
    localparam int SET_W = tpc_pkg::idx_bits(NSETS);
    localparam int TAG_W = BLK_W - SET_W;
    localparam int WAY_W = tpc_pkg::idx_bits(WAYS);

    logic [TAG_W-1:0] tag_q [NSETS][WAYS];
    logic [WAY_W-1:0] age_q [NSETS][WAYS];
    logic [WAYS-1:0]  vld_q [NSETS];

    logic [SET_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [WAY_W-1:0] hit_way, vic_way, way;
    logic             inv_found;

    assign set_i = lk_blk[SET_W-1:0];
    assign tag_i = lk_blk[BLK_W-1:SET_W];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && vld_q[set_i][w] && tag_q[set_i][w] == tag_i) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // Victim: lowest invalid way, else the way whose age is oldest.
    always_comb begin
        inv_found = 1'b0;
        vic_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!inv_found && !vld_q[set_i][w]) begin
                inv_found = 1'b1;
                vic_way   = WAY_W'(w);
            end
        end
        if (!inv_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_i][w] == WAY_W'(WAYS - 1)) vic_way = WAY_W'(w);
            end
        end
    end

    assign way  = hit ? hit_way : vic_way;
    assign line = LINE_W'(set_i) * LINE_W'(WAYS) + LINE_W'(way);

    always_ff @(posedge clk) begin
        if (lk_en) tag_q[set_i][way] <= tag_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (lk_en) begin
            vld_q[set_i][way] <= 1'b1;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == way)
                    age_q[set_i][w] <= '0;
                else if (age_q[set_i][w] < age_q[set_i][way])
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tex_prefetch_cache.sv
module tex_prefetch_cache
    import tpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 8,
    parameter int NSETS      = 8,
    parameter int WAYS       = 20,
    parameter int LINE_BYTES = 32,
    parameter int FRAG_DEPTH = 128,
    parameter int REQ_DEPTH  = 4,
    parameter int ROB_DEPTH  = 16,
    parameter int RES_DEPTH  = 2,
    // Derived widths; keep at their defaults.
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LINE_W     = $clog2(NSETS * WAYS),
    parameter int SLOT_W     = idx_bits(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic [1:0]        req_status,
    input  logic              mem_full,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [SLOT_W-1:0] mem_req_slot,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              rsp_pop,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [LINE_W-1:0] rsp_line,
    output logic [OFF_W-1:0]  rsp_off
);
    localparam int BLK_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  off;
        logic              miss;
    } frag_t;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [SLOT_W-1:0] slot;
    } mreq_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LINE_W-1:0] line;
    } rob_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  off;
    } res_t;

    logic              accept, tag_hit;
    logic [LINE_W-1:0] tag_line;
    acc_status_e       status;

    frag_t             frag_in, frag_head;
    logic              frag_full, frag_empty;
    mreq_t             mreq_in, mreq_head;
    logic              reqf_full, reqf_empty, reqf_pop;
    rob_t              rob_in, rob_head;
    logic [SLOT_W-1:0] rob_slot;
    logic              rob_full, rob_empty, rob_head_ready;
    res_t              res_in, res_head;
    logic              res_full, res_empty;
    logic              retire;

    // ---------------- acceptance and lookup ----------------
    assign accept = req_valid && !frag_full && !reqf_full && !rob_full;

    always_comb begin
        status = ST_REFUSED;
        if (accept) status = tag_hit ? ST_HIT_PENDING : ST_MISS;
    end
    assign req_status = status;

    tpc_tags #(
        .BLK_W (BLK_W),
        .NSETS (NSETS),
        .WAYS  (WAYS),
        .LINE_W(LINE_W)
    ) u_tags (
        .clk   (clk),
        .rst   (rst),
        .lk_en (accept),
        .lk_blk(req_addr[ADDR_W-1:OFF_W]),
        .hit   (tag_hit),
        .line  (tag_line)
    );

    assign frag_in = '{id: req_id, line: tag_line, off: req_addr[OFF_W-1:0], miss: !tag_hit};
    assign rob_in  = '{id: req_id, line: tag_line};
    assign mreq_in = '{blk: req_addr[ADDR_W-1:OFF_W], slot: rob_slot};

    tpc_fifo #(.W($bits(frag_t)), .DEPTH(FRAG_DEPTH)) u_frag (
        .clk(clk), .rst(rst),
        .push(accept), .din(frag_in),
        .pop(retire), .dout(frag_head),
        .full(frag_full), .empty(frag_empty)
    );

    tpc_rob #(.W($bits(rob_t)), .DEPTH(ROB_DEPTH), .SLOT_W(SLOT_W)) u_rob (
        .clk(clk), .rst(rst),
        .push(accept && !tag_hit), .din(rob_in), .push_slot(rob_slot),
        .pop(retire && frag_head.miss), .head(rob_head), .head_ready(rob_head_ready),
        .full(rob_full), .empty(rob_empty),
        .fill_valid(fill_valid), .fill_slot(fill_slot)
    );

    // ---------------- memory request path ----------------
    tpc_fifo #(.W($bits(mreq_t)), .DEPTH(REQ_DEPTH)) u_reqf (
        .clk(clk), .rst(rst),
        .push(accept && !tag_hit), .din(mreq_in),
        .pop(reqf_pop), .dout(mreq_head),
        .full(reqf_full), .empty(reqf_empty)
    );

    assign mem_req_valid = !reqf_empty;
    assign reqf_pop      = !reqf_empty && !mem_full;
    assign mem_req_addr  = {mreq_head.blk, {OFF_W{1'b0}}};
    assign mem_req_slot  = mreq_head.slot;

    // ---------------- in-order retirement ----------------
    assign retire = !frag_empty && !res_full && (!frag_head.miss || rob_head_ready);
    assign res_in = '{id:   frag_head.id,
                      line: frag_head.miss ? rob_head.line : frag_head.line,
                      off:  frag_head.off};

    tpc_fifo #(.W($bits(res_t)), .DEPTH(RES_DEPTH)) u_res (
        .clk(clk), .rst(rst),
        .push(retire), .din(res_in),
        .pop(rsp_pop && !res_empty), .dout(res_head),
        .full(res_full), .empty(res_empty)
    );

    assign rsp_valid = !res_empty;
    assign rsp_id    = res_head.id;
    assign rsp_line  = res_head.line;
    assign rsp_off   = res_head.off;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 8,
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_status,
    input logic              mem_full,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [SLOT_W-1:0] mem_req_slot,
    input logic              fill_valid,
    input logic              rob_empty,
    input logic              frag_empty,
    input logic              frag_head_miss,
    input logic [ID_W-1:0]   frag_head_id,
    input logic [ID_W-1:0]   rob_head_id,
    input logic              rsp_valid,
    input logic              rsp_pop,
    input logic [ID_W-1:0]   rsp_id
);
    AST_MISS_SENDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_status == 2'b10) |=> mem_req_valid); // R6

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_full) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_slot))); // R6

    AST_FILL_OWNED: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !rob_empty); // R7

    AST_HEAD_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!frag_empty && frag_head_miss) |-> (!rob_empty && rob_head_id == frag_head_id)); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_pop) |=> (rsp_valid && $stable(rsp_id))); // R9

    AST_NO_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> req_status == 2'b00); // R2
endmodule

bind tex_prefetch_cache tpc_checker #(
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W),
    .SLOT_W(SLOT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_status    (req_status),
    .mem_full      (mem_full),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_slot  (mem_req_slot),
    .fill_valid    (fill_valid),
    .rob_empty     (rob_empty),
    .frag_empty    (frag_empty),
    .frag_head_miss(frag_head.miss),
    .frag_head_id  (frag_head.id),
    .rob_head_id   (rob_head.id),
    .rsp_valid     (rsp_valid),
    .rsp_pop       (rsp_pop),
    .rsp_id        (rsp_id)
);

// File: tb/tb_tex_prefetch_cache.sv
module tb_tex_prefetch_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 8;
    localparam int NSETS  = 2;
    localparam int WAYS   = 2;
    localparam int LINE_BYTES = 32;
    localparam int FRAG_DEPTH = 6;
    localparam int REQ_DEPTH  = 2;
    localparam int ROB_DEPTH  = 3;
    localparam int RES_DEPTH  = 2;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = $clog2(NSETS * WAYS);
    localparam int SLOT_W = $clog2(ROB_DEPTH);

    localparam logic [1:0] S_FAIL = 2'b00;
    localparam logic [1:0] S_HIT  = 2'b01;
    localparam logic [1:0] S_MISS = 2'b10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [1:0]        req_status;
    logic              mem_full = 1'b1;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [SLOT_W-1:0] mem_req_slot;
    logic              fill_valid = 1'b0;
    logic [SLOT_W-1:0] fill_slot = '0;
    logic              rsp_pop = 1'b0;
    logic              rsp_valid;
    logic [ID_W-1:0]   rsp_id;
    logic [LINE_W-1:0] rsp_line;
    logic [OFF_W-1:0]  rsp_off;

    int errs = 0;
    int checks = 0;
    int slot_ctr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tex_prefetch_cache #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .NSETS(NSETS), .WAYS(WAYS),
        .LINE_BYTES(LINE_BYTES), .FRAG_DEPTH(FRAG_DEPTH), .REQ_DEPTH(REQ_DEPTH),
        .ROB_DEPTH(ROB_DEPTH), .RES_DEPTH(RES_DEPTH)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id), .req_status(req_status),
        .mem_full(mem_full), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_slot(mem_req_slot), .fill_valid(fill_valid), .fill_slot(fill_slot),
        .rsp_pop(rsp_pop), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .rsp_line(rsp_line), .rsp_off(rsp_off)
    );

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a, input int id,
                         input logic [1:0] exp, input string r);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_id    = ID_W'(id);
        #1;
        chk(req_status == exp, r, "status", req_status, exp);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic mem_take(input logic [ADDR_W-1:0] exp_addr, input string r, output int slot);
        @(negedge clk);
        chk(mem_req_valid == 1'b1, r, "mem_req_valid", mem_req_valid, 1);
        chk(mem_req_addr == exp_addr, r, "mem_req_addr", mem_req_addr, exp_addr);
        chk(mem_req_slot == SLOT_W'(slot_ctr), "R7", "mem_req_slot", mem_req_slot, slot_ctr);
        slot     = int'(mem_req_slot);
        slot_ctr = (slot_ctr + 1) % ROB_DEPTH;
        mem_full = 1'b0;
        @(posedge clk);
        #1 mem_full = 1'b1;
    endtask

    task automatic fill(input int s);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_slot  = SLOT_W'(s);
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic expect_rsp(input int id, input int line, input int off, input string r);
        int n = 0;
        @(negedge clk);
        while (!rsp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(rsp_valid == 1'b1, r, "rsp_valid", rsp_valid, 1);
        chk(rsp_id == ID_W'(id), r, "rsp_id", rsp_id, id);
        chk(rsp_line == LINE_W'(line), r, "rsp_line", rsp_line, line);
        chk(rsp_off == OFF_W'(off), r, "rsp_off", rsp_off, off);
        rsp_pop = 1'b1;
        @(posedge clk);
        #1 rsp_pop = 1'b0;
    endtask

    task automatic quiet(input int n, input string r);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (rsp_valid) seen = 1'b1;
        end
        chk(!seen, r, "no response expected", seen, 0);
    endtask

    task automatic miss_trip(input logic [ADDR_W-1:0] a, input int id, input int line);
        int s;
        issue(a, id, S_MISS, "R3");
        mem_take({a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}, "R6", s);
        fill(s);
        expect_rsp(id, line, int'(a[OFF_W-1:0]), "R5");
    endtask

    task automatic hit_trip(input logic [ADDR_W-1:0] a, input int id, input int line);
        issue(a, id, S_HIT, "R3");
        expect_rsp(id, line, int'(a[OFF_W-1:0]), "R5");
    endtask

    // R1: idle outputs after reset
    task automatic t_reset();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
    endtask

    // R5: invalid-first then LRU victim in set 0
    task automatic t_lru();
        miss_trip(32'h000, 1, 0);
        miss_trip(32'h040, 2, 1);
        hit_trip (32'h004, 3, 0);
        miss_trip(32'h080, 4, 1);   // evicts 0x040
        miss_trip(32'h040, 5, 0);   // evicts 0x000
        hit_trip (32'h09C, 6, 1);
    endtask

    // R4, R6, R8: hit on an unfilled line waits behind the miss
    task automatic t_pending_hit();
        int s;
        issue(32'h020, 10, S_MISS, "R3");
        issue(32'h028, 11, S_HIT, "R4");
        repeat (3) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == 32'h020, "R6", "held request",
            mem_req_addr, 32'h020);
        mem_take(32'h020, "R6", s);
        quiet(5, "R8");
        fill(s);
        expect_rsp(10, 2, 0, "R8");
        expect_rsp(11, 2, 8, "R8");
    endtask

    // R7, R8: younger fill first, still delivered in order
    task automatic t_out_of_order();
        int s0, s1;
        issue(32'h060, 20, S_MISS, "R3");
        issue(32'h0A0, 21, S_MISS, "R3");
        mem_take(32'h060, "R6", s0);
        mem_take(32'h0A0, "R6", s1);
        fill(s1);
        quiet(5, "R8");
        fill(s0);
        expect_rsp(20, 3, 0, "R8");
        expect_rsp(21, 2, 0, "R8");
    endtask

    // R2: request queue full refuses even a would-be hit
    task automatic t_reqf_full();
        int s0, s1;
        issue(32'h0C0, 30, S_MISS, "R3");
        issue(32'h100, 31, S_MISS, "R3");
        issue(32'h0C4, 32, S_FAIL, "R2");
        mem_take(32'h0C0, "R6", s0);
        mem_take(32'h100, "R6", s1);
        fill(s0);
        fill(s1);
        expect_rsp(30, 0, 0, "R2");
        expect_rsp(31, 1, 0, "R2");
        quiet(6, "R2");
        chk(mem_req_valid == 1'b0, "R2", "no request from refused access", mem_req_valid, 0);
    endtask

    // R2, R7, R8: reorder buffer full; fills in scrambled order
    task automatic t_rob_full();
        int si, sj, sk;
        issue(32'h140, 40, S_MISS, "R3");
        mem_take(32'h140, "R6", si);
        issue(32'h1A0, 41, S_MISS, "R3");
        mem_take(32'h1A0, "R6", sj);
        issue(32'h1E0, 42, S_MISS, "R3");
        mem_take(32'h1E0, "R6", sk);
        issue(32'h1A4, 43, S_FAIL, "R2");
        fill(sk);
        quiet(3, "R8");
        fill(si);
        fill(sj);
        expect_rsp(40, 0, 0, "R8");
        expect_rsp(41, 3, 0, "R8");
        expect_rsp(42, 2, 0, "R8");
        quiet(4, "R2");
    endtask

    // R2, R9: fragment queue full, then result queue backpressure
    task automatic t_frag_full();
        int s;
        issue(32'h200, 50, S_MISS, "R3");
        for (int k = 1; k <= 5; k++) issue(32'h200 + k, 50 + k, S_HIT, "R4");
        issue(32'h204, 60, S_FAIL, "R2");
        mem_take(32'h200, "R6", s);
        fill(s);
        repeat (6) @(negedge clk);
        chk(rsp_valid && rsp_id == 8'd50, "R9", "head held under backpressure", rsp_id, 50);
        for (int k = 0; k <= 5; k++) expect_rsp(50 + k, 1, k, "R9");
        quiet(4, "R9");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_lru();
        t_pending_hit();
        t_out_of_order();
        t_reqf_full();
        t_rob_full();
        t_frag_full();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule